// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block runs the cycle sequencing of a single-port, pipelined synchronous burst SRAM with a 64-bit word and a small parametric depth. Each rising clock edge classifies the inputs as one of four cycles: a processor-strobe load, a controller-strobe load, a continue (advance) cycle or a wait cycle. Five chip enables of mixed polarity are evaluated only when a new external address is loaded. The result is latched as a selection state that later continue and wait cycles reuse. A two-bit burst counter produces the low address bits in interleaved or linear order. A lane decoder turns the global-write and per-byte write controls into a byte mask.

The access stage drives read and write strobes into a behavioural array that sits inside the block for testing. Read data pass through a registered output stage, so a read accepted on one edge has its data one edge later. A data-output enable combines the registered read-valid flag with the asynchronous output enable. A snooze request is brought into the clock domain through two flops. While it is active, all access stops and the array contents are kept. The reset `rst_n` is asynchronous, and its deassertion is expected to be synchronous to `clk`.

Top module: `sbsram_ctrl`

## Requirements
- R1: The device becomes selected at a load only when `ce_main_n`=0, `ce_lo0_n`=0, `ce_lo1_n`=0, `ce_hi0`=1 and `ce_hi1`=1. A load with any enable false deselects: no array access follows, and `rdata_oe` is low from the second edge after it.
- R2: Chip enables are only looked at on a load edge. After a deselect, continue and wait cycles make no access even with every enable true. After a select, continue and wait cycles go on even if the enables change.
- R3: `ld_cpu_n`=0 with `ce_main_n`=0 loads `addr_i` and starts a read even when write controls are active. With `ce_main_n`=1, `ld_cpu_n` is ignored and the cycle behaves as a continue or wait cycle.
- R4: `ld_ctl_n`=0 (without a processor load) loads `addr_i` and starts a write if any lane is enabled, otherwise a read. `wr_all_n`=0 writes all lanes. With `wr_byte_en_n`=0, lane i (`wdata[8i+7:8i]`) is written when `wr_lane_n[i]`=0. The lane bits are ignored while `wr_byte_en_n`=1.
- R5: On a cycle with both strobes high, `adv_n`=0 steps the burst count (mod 4) and `adv_n`=1 repeats the current address. The low two address bits are start XOR count when `linear_mode`=0, and start plus count mod 4 when `linear_mode`=1. The upper bits stay fixed.
- R6: A read accepted on edge k presents the word on `rdata` after edge k+1. `rdata_oe` is high then while `oe_n`=0, and `oe_n`=1 forces `rdata_oe` low without waiting for a clock.
- R7: After reset `rdata_oe`, `arr_rd` and `arr_wr_be` are 0. The output is not enabled on the edge that accepts the first read, only after the edge that follows it.
- R8: A read of an address accepted on the edge right after a write to it returns the newly written lanes merged with the old ones.
- R9: After a write cycle, `rdata_oe` stays low until the edge following a read cycle.
- R10: `snooze` passes through two flops. Accesses accepted before the second edge after it rises still complete, a write pending at that point is dropped, and no access happens while it is active. Operation resumes on the third edge after it falls, and the array contents are kept throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| ce_main_n | input | 1 | Primary enable, active low; also qualifies the processor strobe |
| ce_lo0_n | input | 1 | Secondary enable, active low |
| ce_lo1_n | input | 1 | Secondary enable, active low |
| ce_hi0 | input | 1 | Secondary enable, active high |
| ce_hi1 | input | 1 | Secondary enable, active high |
| ld_cpu_n | input | 1 | Processor address strobe, active low |
| ld_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_en_n | input | 1 | Gate for per-lane writes, active low |
| wr_lane_n | input | DATA_W/BYTE_W | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Asynchronous low-power request, active high |
| linear_mode | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | Drive enable for the data bus |
| arr_rd | output | 1 | Array read strobe of the access stage |
| arr_wr_be | output | DATA_W/BYTE_W | Array lane write strobes of the access stage |
| arr_addr | output | ADDR_W | Array address of the access stage |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words) and a 64-bit word split into eight byte lanes. With that setting, a four-word burst window at addresses 0x08 to 0x0B can be written and read back in both burst orders. Every lane pattern, including sparse lane masks, can be told apart in a single word. The small depth lets the bench track the whole array contents across the snooze entry and recovery windows.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_op_e;

  // Low two address bits of a burst beat from the start bits and the count.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] count,
                                         input logic       linear);
    if (linear) beat_lo = start + count;
    else        beat_lo = start ^ count;
  endfunction

endpackage

// File: rtl/sbsram_wr_dec.sv
module sbsram_wr_dec #(
  parameter int NB = 8
) (
  input  logic          wr_all_n,
  input  logic          wr_byte_en_n,
  input  logic [NB-1:0] wr_lane_n,
  output logic [NB-1:0] lane_we,
  output logic          any_we
);

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign lane_we[l] = !wr_all_n || (!wr_byte_en_n && !wr_lane_n[l]);
  end

  assign any_we = |lane_we;

endmodule

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen
  import sbsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] load_lo,
  input  logic       linear,
  output logic [1:0] lo_now
);

  logic [1:0] start_q, start_d;
  logic [1:0] count_q, count_d;

  always_comb begin
    start_d = start_q;
    count_d = count_q;
    if (load) begin
      start_d = load_lo;
      count_d = 2'd0;
    end else if (step) begin
      count_d = count_q + 2'd1;
    end
    lo_now = beat_lo(start_d, count_d, linear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 2'd0;
      count_q <= 2'd0;
    end else if (load || step) begin
      start_q <= start_d;
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  parameter int NB     = 8
) (
  input  logic                 clk,
  input  logic [NB-1:0]        lane_we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NB*BYTE_W-1:0] wdata,
  output logic [NB*BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[addr] <= wdata[l*BYTE_W +: BYTE_W];
    end

    assign rdata[l*BYTE_W +: BYTE_W] = mem[addr];
  end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       ce_main_n,
  input  logic                       ce_lo0_n,
  input  logic                       ce_lo1_n,
  input  logic                       ce_hi0,
  input  logic                       ce_hi1,
  input  logic                       ld_cpu_n,
  input  logic                       ld_ctl_n,
  input  logic                       adv_n,
  input  logic                       wr_all_n,
  input  logic                       wr_byte_en_n,
  input  logic [DATA_W/BYTE_W-1:0]   wr_lane_n,
  input  logic                       oe_n,
  input  logic                       snooze,
  input  logic                       linear_mode,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rdata_oe,
  output logic                       arr_rd,
  output logic [DATA_W/BYTE_W-1:0]   arr_wr_be,
  output logic [ADDR_W-1:0]          arr_addr
);

  localparam int NB   = DATA_W / BYTE_W;
  localparam int HI_W = ADDR_W - 2;

  // snooze synchronizer
  logic snz_meta, snz_q;

  // selection and address state
  logic            sel_q, sel_d;
  logic [HI_W-1:0] hi_q, hi_d;

  // access stage
  logic              s1_rd_q, s1_rd_d;
  logic [NB-1:0]     s1_be_q, s1_be_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d;
  logic [DATA_W-1:0] s1_wdata_q, s1_wdata_d;

  // output stage
  logic              rdv_q, rdv_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // decode
  logic          en_all, cpu_ld, ctl_ld, ld, step;
  logic [1:0]    lo_now;
  logic [NB-1:0] lane_we;
  logic          any_we;
  acc_op_e       op;
  logic [DATA_W-1:0] arr_q;

  sbsram_wr_dec #(.NB(NB)) u_wr_dec (
    .wr_all_n     (wr_all_n),
    .wr_byte_en_n (wr_byte_en_n),
    .wr_lane_n    (wr_lane_n),
    .lane_we      (lane_we),
    .any_we       (any_we)
  );

  sbsram_burst_gen u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .step    (step),
    .load_lo (addr_i[1:0]),
    .linear  (linear_mode),
    .lo_now  (lo_now)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NB(NB)) u_array (
    .clk     (clk),
    .lane_we (arr_wr_be),
    .addr    (s1_addr_q),
    .wdata   (s1_wdata_q),
    .rdata   (arr_q)
  );

  // cycle classification and next state
  always_comb begin
    en_all = !ce_main_n && !ce_lo0_n && !ce_lo1_n && ce_hi0 && ce_hi1;
    cpu_ld = !ld_cpu_n && !ce_main_n && !snz_q;
    ctl_ld = !ld_ctl_n && !cpu_ld && !snz_q;
    ld     = cpu_ld || ctl_ld;
    step   = !ld && !adv_n && sel_q && !snz_q;

    if (snz_q)   sel_d = 1'b0;
    else if (ld) sel_d = en_all;
    else         sel_d = sel_q;

    hi_d = ld ? addr_i[ADDR_W-1:2] : hi_q;

    if (!sel_d)                 op = ACC_IDLE;
    else if (cpu_ld || !any_we) op = ACC_READ;
    else                        op = ACC_WRITE;

    s1_rd_d    = (op == ACC_READ);
    s1_be_d    = (op == ACC_WRITE) ? lane_we : '0;
    s1_addr_d  = sel_d ? {hi_d, lo_now} : s1_addr_q;
    s1_wdata_d = (op == ACC_WRITE) ? wdata : s1_wdata_q;

    rdv_d   = s1_rd_q && !snz_q;
    rdata_d = rdv_d ? arr_q : rdata_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snz_meta  <= 1'b0;
      snz_q     <= 1'b0;
      sel_q     <= 1'b0;
      hi_q      <= '0;
      s1_rd_q   <= 1'b0;
      s1_be_q   <= '0;
      s1_addr_q <= '0;
      rdv_q     <= 1'b0;
    end else begin
      snz_meta <= snooze;
      snz_q    <= snz_meta;
      sel_q    <= sel_d;
      if (ld)    hi_q      <= hi_d;
      s1_rd_q  <= s1_rd_d;
      s1_be_q  <= s1_be_d;
      if (sel_d) s1_addr_q <= s1_addr_d;
      rdv_q    <= rdv_d;
    end
  end

  // data registers, no reset
  always_ff @(posedge clk) begin
    if (op == ACC_WRITE) s1_wdata_q <= s1_wdata_d;
    if (rdv_d)           rdata_q    <= rdata_d;
  end

  assign arr_rd    = s1_rd_q && !snz_q;
  assign arr_wr_be = snz_q ? '0 : s1_be_q;
  assign arr_addr  = s1_addr_q;
  assign rdata     = rdata_q;
  assign rdata_oe  = rdv_q && !oe_n && !snz_q;

endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int NB     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_cpu_n,
  input logic              ld_ctl_n,
  input logic              adv_n,
  input logic              ce_main_n,
  input logic              ce_lo0_n,
  input logic              ce_lo1_n,
  input logic              ce_hi0,
  input logic              ce_hi1,
  input logic              snooze,
  input logic              snz_q,
  input logic              rdata_oe,
  input logic              arr_rd,
  input logic [NB-1:0]     arr_wr_be,
  input logic [ADDR_W-1:0] arr_addr
);

  logic load_c, en_c, acc_c;
  assign load_c = (!ld_cpu_n && !ce_main_n) || !ld_ctl_n;
  assign en_c   = !ce_main_n && !ce_lo0_n && !ce_lo1_n && ce_hi0 && ce_hi1;
  assign acc_c  = arr_rd || (|arr_wr_be);

  p_deselect_no_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_c && !en_c) |=> !acc_c);

  p_hold_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_c && !load_c) |=> !acc_c);

  p_cpu_load_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && !ce_main_n) |=> (arr_wr_be == '0));

  p_rd_wr_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd && (|arr_wr_be)));

  p_wait_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cpu_n && ld_ctl_n && adv_n && !snz_q && acc_c) |=> $stable(arr_addr));

  p_oe_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(arr_rd));

  p_snooze_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snooze && $past(snooze) && $past(snooze, 2)) |-> (arr_wr_be == '0 && !arr_rd));

endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.ADDR_W(ADDR_W), .NB(NB)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_cpu_n  (ld_cpu_n),
  .ld_ctl_n  (ld_ctl_n),
  .adv_n     (adv_n),
  .ce_main_n (ce_main_n),
  .ce_lo0_n  (ce_lo0_n),
  .ce_lo1_n  (ce_lo1_n),
  .ce_hi0    (ce_hi0),
  .ce_hi1    (ce_hi1),
  .snooze    (snooze),
  .snz_q     (snz_q),
  .rdata_oe  (rdata_oe),
  .arr_rd    (arr_rd),
  .arr_wr_be (arr_wr_be),
  .arr_addr  (arr_addr)
);

// File: tb/sbsram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb_top;

  localparam int AW = 6;
  localparam int DW = 64;
  localparam int NBL = 8;

  localparam logic [4:0] EN_ALL  = 5'b00011;
  localparam logic [4:0] EN_PRI  = 5'b10011;
  localparam logic [4:0] EN_HIB  = 5'b00010;

  localparam logic [63:0] DA  = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DB  = 64'h5555_6666_7777_8888;
  localparam logic [63:0] DC  = 64'h9999_AAAA_BBBB_CCCC;
  localparam logic [63:0] DD  = 64'hDDDD_EEEE_FFFF_0123;
  localparam logic [63:0] DF  = 64'hDEAD_BEEF_0BAD_F00D;
  localparam logic [63:0] DB2 = 64'h5555_6666_7777_88AA;
  localparam logic [63:0] DC2 = 64'h9900_AA00_BB00_CC00;
  localparam logic [63:0] DZ  = 64'h0F0F_1E1E_2D2D_3C3C;

  typedef struct packed {
    logic        cpu_n;
    logic        ctl_n;
    logic        adv;
    logic [4:0]  ce;
    logic        gw_n;
    logic        be_n;
    logic [7:0]  bw_n;
    logic        o_n;
    logic [5:0]  ad;
    logic [63:0] wd;
    logic        exp_oe;
    logic [63:0] exp_rd;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b1,EN_ALL,1'b0,1'b1,8'hFF,1'b0,6'h08,DA,1'b0,64'h0},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b0,1'b1,8'hFF,1'b0,6'h00,DB,1'b0,64'h0},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b0,1'b1,8'hFF,1'b0,6'h00,DC,1'b0,64'h0},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b0,1'b1,8'hFF,1'b0,6'h00,DD,1'b0,64'h0},
    '{1'b0,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h08,64'h0,1'b0,64'h0},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DA},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DB},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DC},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DC},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DD},
    '{1'b1,1'b0,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h0A,64'h0,1'b1,DA},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DC},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DD},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DA},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b1,6'h00,64'h0,1'b0,64'h0},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DB},
    '{1'b1,1'b0,1'b1,EN_HIB,1'b1,1'b1,8'hFF,1'b0,6'h10,64'h0,1'b1,DB},
    '{1'b1,1'b1,1'b0,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b0,64'h0},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b0,64'h0},
    '{1'b0,1'b1,1'b1,EN_ALL,1'b0,1'b1,8'hFF,1'b0,6'h09,DF,1'b0,64'h0},
    '{1'b0,1'b1,1'b1,EN_PRI,1'b1,1'b1,8'hFF,1'b0,6'h20,64'h0,1'b1,DB},
    '{1'b1,1'b0,1'b1,EN_ALL,1'b1,1'b0,8'hFE,1'b0,6'h09,64'hFFFF_FFFF_FFFF_FFAA,1'b1,DB},
    '{1'b1,1'b0,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h09,64'h0,1'b0,64'h0},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DB2},
    '{1'b1,1'b0,1'b1,EN_ALL,1'b1,1'b1,8'h00,1'b0,6'h08,64'h0,1'b1,DB2},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DA},
    '{1'b1,1'b0,1'b1,EN_ALL,1'b1,1'b0,8'hAA,1'b0,6'h0A,64'h0,1'b1,DA},
    '{1'b0,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h0A,64'h0,1'b0,64'h0},
    '{1'b1,1'b1,1'b1,EN_ALL,1'b1,1'b1,8'hFF,1'b0,6'h00,64'h0,1'b1,DC2}
  };

  logic          clk, rst_n;
  logic [AW-1:0] addr_i;
  logic          ce_main_n, ce_lo0_n, ce_lo1_n, ce_hi0, ce_hi1;
  logic          ld_cpu_n, ld_ctl_n, adv_n;
  logic          wr_all_n, wr_byte_en_n;
  logic [NBL-1:0] wr_lane_n;
  logic          oe_n, snooze, linear_mode;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_oe, arr_rd;
  logic [NBL-1:0] arr_wr_be;
  logic [AW-1:0] arr_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sbsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .ce_main_n(ce_main_n), .ce_lo0_n(ce_lo0_n), .ce_lo1_n(ce_lo1_n),
    .ce_hi0(ce_hi0), .ce_hi1(ce_hi1),
    .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .wr_lane_n(wr_lane_n),
    .oe_n(oe_n), .snooze(snooze), .linear_mode(linear_mode), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .arr_rd(arr_rd),
    .arr_wr_be(arr_wr_be), .arr_addr(arr_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drv(input logic c_n, input logic t_n, input logic a_n,
                     input logic [4:0] ce, input logic g_n, input logic b_n,
                     input logic [7:0] l_n, input logic o_n,
                     input logic [5:0] ad, input logic [63:0] wd);
    ld_cpu_n = c_n; ld_ctl_n = t_n; adv_n = a_n;
    {ce_main_n, ce_lo0_n, ce_lo1_n, ce_hi0, ce_hi1} = ce;
    wr_all_n = g_n; wr_byte_en_n = b_n; wr_lane_n = l_n;
    oe_n = o_n; addr_i = ad; wdata = wd;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input int i);
    if (i < 4)       tag_of = "R4";
    else if (i < 14) tag_of = "R5";
    else if (i < 16) tag_of = "R6";
    else if (i < 17) tag_of = "R1";
    else if (i < 19) tag_of = "R2";
    else if (i < 22) tag_of = "R3";
    else if (i < 23) tag_of = "R9";
    else if (i < 24) tag_of = "R8";
    else if (i < 27) tag_of = "R4";
    else if (i < 28) tag_of = "R9";
    else             tag_of = "R4";
  endfunction

  initial begin
    rst_n = 1'b0;
    snooze = 1'b0;
    linear_mode = 1'b0;
    drv(1, 1, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R7: reset state
    chk("R7 reset oe", {63'h0, rdata_oe}, 64'h0);
    chk("R7 reset rd", {63'h0, arr_rd}, 64'h0);
    chk("R7 reset wr", {56'h0, arr_wr_be}, 64'h0);

    // R7: first read is not driven on its own edge, only after the next
    @(negedge clk); drv(1, 0, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h30, 64'h0); cyc();
    chk("R7 first edge oe", {63'h0, rdata_oe}, 64'h0);
    @(negedge clk); drv(1, 0, 1, EN_HIB, 1, 1, 8'hFF, 0, 6'h30, 64'h0); cyc();
    chk("R7 next edge oe", {63'h0, rdata_oe}, 64'h1);
    @(negedge clk); drv(1, 1, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0); cyc();
    chk("R7 after deselect oe", {63'h0, rdata_oe}, 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drv(VECS[i].cpu_n, VECS[i].ctl_n, VECS[i].adv, VECS[i].ce, VECS[i].gw_n,
          VECS[i].be_n, VECS[i].bw_n, VECS[i].o_n, VECS[i].ad, VECS[i].wd);
      cyc();
      chk($sformatf("%s vec %0d oe", tag_of(i), i), {63'h0, rdata_oe}, {63'h0, VECS[i].exp_oe});
      if (VECS[i].exp_oe)
        chk($sformatf("%s vec %0d data", tag_of(i), i), rdata, VECS[i].exp_rd);
    end

    // R5: linear burst from 0x09: 09, 0A, 0B, 08
    @(negedge clk); linear_mode = 1'b1;
    drv(1, 0, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h09, 64'h0); cyc();
    @(negedge clk); drv(1, 1, 0, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0); cyc();
    chk("R5 linear beat0", rdata, DB2);
    @(negedge clk); drv(1, 1, 0, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0); cyc();
    chk("R5 linear beat1", rdata, DC2);
    @(negedge clk); drv(1, 1, 0, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0); cyc();
    chk("R5 linear beat2", rdata, DD);
    @(negedge clk); drv(1, 1, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0); cyc();
    chk("R5 linear wrap", rdata, DA);
    @(negedge clk); linear_mode = 1'b0;

    // R10: snooze entry, pending write dropped, recovery
    snooze = 1'b1;
    drv(1, 0, 1, EN_ALL, 0, 1, 8'hFF, 0, 6'h0B, DZ); cyc();
    @(negedge clk); drv(1, 0, 1, EN_ALL, 0, 1, 8'hFF, 0, 6'h08, DZ); cyc();
    @(negedge clk); drv(1, 0, 1, EN_ALL, 0, 1, 8'hFF, 0, 6'h09, DZ); cyc();
    chk("R10 snooze no write", {56'h0, arr_wr_be}, 64'h0);
    chk("R10 snooze oe", {63'h0, rdata_oe}, 64'h0);
    @(negedge clk); cyc();
    chk("R10 snooze ignores load", {56'h0, arr_wr_be}, 64'h0);
    @(negedge clk); snooze = 1'b0;
    drv(1, 0, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h0B, 64'h0); cyc();
    chk("R10 recovery edge1", {63'h0, arr_rd}, 64'h0);
    @(negedge clk); cyc();
    chk("R10 recovery edge2", {63'h0, arr_rd}, 64'h0);
    @(negedge clk); cyc();
    chk("R10 recovery edge3", {63'h0, arr_rd}, 64'h1);
    @(negedge clk); drv(1, 0, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h08, 64'h0); cyc();
    chk("R10 write before entry kept", rdata, DZ);
    @(negedge clk); drv(1, 0, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h09, 64'h0); cyc();
    chk("R10 pending write dropped", rdata, DA);
    @(negedge clk); drv(1, 1, 1, EN_ALL, 1, 1, 8'hFF, 0, 6'h00, 64'h0); cyc();
    chk("R10 array retained", rdata, DB2);

    finish_run();
  end

endmodule